// File: doc/BRIEF.md
# SD Host Ping-Pong Data Buffer

This block is the data store between a 32-bit host word port, driven by DMA or by the processor, and the serializer that drives the SD data lines. It moves data in both directions. It holds two equal buffers, X and Y. The host fills or drains one buffer while the card side exchanges the other with the card, so a multi-block transfer streams without gaps as long as the host keeps pace.

Each buffer is split into four per-line containers of 16 bytes. In 4-bit bus mode all four containers are in use, so a buffer holds 64 bytes. In 1-bit mode only line 0's container is used, so a buffer holds 16 bytes.

The block raises a DMA request together with a write-ready or read-ready flag. It also reports per-buffer full and empty flags. During reads it raises a clock-stop request when no buffer is free. This holds the card clock at the block gap instead of losing data. Bus width, direction and transfer length are captured when a transfer starts. An abort returns both buffers to empty.

Top module: `sd_pingpong_buf`

## Requirements
- R1: After reset both empty flags are 1 (bit 0 is buffer X, bit 1 is buffer Y). Both full flags are 0. The DMA request, the ready flags, the card-side valid/ready outputs and the clock-stop request are all 0.
- R2: Card-side mapping in 4-bit mode: each byte is sent as two nibbles, high nibble first, and data line n carries bit n of the nibble. In 1-bit mode each byte goes on line 0, MSB first; lines 1 to 3 are driven 0 on transmit and ignored on receive. A buffer holds 64 bytes in 4-bit mode and 16 bytes in 1-bit mode.
- R3: Host word order: byte k of a host word occupies bits [8k+7:8k], and the lowest-addressed byte is in byte lane 0. On a card write, whenever the buffer the host is filling is empty and bytes remain, host_wready, wr_rdy and dma_req are all high.
- R4: On a card write, card_tx_valid rises only after a buffer is complete. A complete buffer is either a full buffer or one holding the final bytes of the transfer. One unit moves on each cycle where card_tx_valid and card_tx_ready are both high.
- R5: On a card read, once the buffer the host drains is full, host_rvalid, rd_rdy and dma_req are all high.
- R6: On a card read, card_rx_ready is high only while the buffer being filled is not full. Data offered while card_rx_ready is low is ignored.
- R7: On a card read, clk_stop_req is high exactly while both buffers are full. It drops in the cycle after the host fetches the last word of a buffer.
- R8: A buffer becomes free again only after all of its bytes have been fetched by the host (read) or sent to the card (write). Buffers are used strictly in turn, X first.
- R9: When fewer bytes remain than a buffer holds, the buffer is marked full as soon as those remaining bytes are in. It is not marked full before that.
- R10: xfer_abort empties both buffers and drops dma_req and clk_stop_req in the next cycle. The next transfer starts with buffer X.
- R11: Bus width, direction and length are sampled on xfer_start. Changes to those inputs during a transfer have no effect.
- R12: The transfer length is a multiple of 4 bytes. After the last byte has crossed, both empty flags return to 1 and dma_req returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_start | input | 1 | Begins a transfer when idle |
| xfer_abort | input | 1 | Cancels the transfer and empties both buffers |
| xfer_rx | input | 1 | 1: card to host, 0: host to card |
| bus_wide | input | 1 | 1: 4-bit bus, 0: 1-bit bus |
| xfer_bytes | input | LEN_W | Transfer length in bytes, multiple of 4 |
| host_wdata | input | HOST_W | Host write word |
| host_wvalid | input | 1 | Host write word valid |
| host_wready | output | 1 | Block accepts the host word |
| host_rdata | output | HOST_W | Host read word |
| host_rvalid | output | 1 | Host read word valid |
| host_rready | input | 1 | Host takes the read word |
| card_tx_data | output | 4 | Data-line unit toward the card |
| card_tx_valid | output | 1 | Transmit unit valid |
| card_tx_ready | input | 1 | Serializer takes the unit |
| card_rx_data | input | 4 | Data-line unit from the card |
| card_rx_valid | input | 1 | Receive unit valid |
| card_rx_ready | output | 1 | Block accepts the receive unit |
| dma_req | output | 1 | DMA service request |
| wr_rdy | output | 1 | Host may write |
| rd_rdy | output | 1 | Host may read |
| buf_full | output | 2 | Full flags, bit 0 X, bit 1 Y |
| buf_empty | output | 2 | Empty flags, bit 0 X, bit 1 Y |
| clk_stop_req | output | 1 | Hold card clock at the block gap |

## Verification
Random streams run in both directions and in both bus widths. Lengths are chosen to end on a partial buffer, and random valid/ready throttling on both sides varies how far the host and the card drift apart. A 1-bit read with random noise on lines 1 to 3 separates correct lane steering from lanes that leak into the data. A directed read with a stalled host fills both buffers: it checks the X-then-Y order, shows that data offered during a clock stop does not reach a buffer, and shows the stop being released when one buffer drains. Further cases cover an abort followed by a fresh start from X, a short block that is full only at its last nibble, and mode inputs that flip mid-transfer.

// File: rtl/sd_pingpong_pkg.sv
package sd_pingpong_pkg;
   localparam int SD_LINES = 4;
   typedef logic [SD_LINES-1:0] sd_unit_t;
   typedef enum logic {
      DIR_TO_CARD   = 1'b0,
      DIR_FROM_CARD = 1'b1
   } xfer_dir_e;
endpackage

// File: rtl/sd_pingpong_ctrl.sv
module sd_pingpong_ctrl
   import sd_pingpong_pkg::*;
#(
   parameter int BUF_BYTES  = 64,
   parameter int HOST_BYTES = 4,
   parameter int LEN_W      = 16,
   localparam int NARROW    = BUF_BYTES / SD_LINES,
   localparam int BLEN_W    = $clog2(BUF_BYTES + 1),
   localparam int OFF_W     = $clog2(BUF_BYTES),
   localparam int ADDR_W    = $clog2(BUF_BYTES * 8 / SD_LINES),
   localparam int CU_W      = ADDR_W + 1,
   localparam int UNIT_W    = BLEN_W + 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              abort,
   input  logic              start,
   input  logic              rx_i,
   input  logic              wide_i,
   input  logic [LEN_W-1:0]  len_i,
   input  logic              h_wvalid,
   output logic              h_wready,
   output logic              h_rvalid,
   input  logic              h_rready,
   output logic              c_tx_valid,
   input  logic              c_tx_ready,
   input  logic              c_rx_valid,
   output logic              c_rx_ready,
   output logic              wide_q,
   output logic              hptr,
   output logic [OFF_W-1:0]  host_addr,
   output logic              host_we,
   output logic              cptr,
   output logic [ADDR_W-1:0] card_addr,
   output logic              card_we,
   output logic              dma_req,
   output logic              wr_rdy,
   output logic              rd_rdy,
   output logic [1:0]        buf_full,
   output logic [1:0]        buf_empty,
   output logic              clk_stop
);
   logic              active;
   xfer_dir_e         dir_q;
   logic [LEN_W-1:0]  h_rem, c_rem;
   logic [1:0]        full_q;
   logic [BLEN_W-1:0] blen [2];
   logic [BLEN_W-1:0] hoff;
   logic [CU_W-1:0]   cunit;
   logic [BLEN_W-1:0] bufsz, rx_chunk, card_bytes;
   logic [UNIT_W-1:0] card_units;
   logic              host_go, card_go, h_last, c_last, xfer_done;

   assign bufsz = wide_q ? BLEN_W'(BUF_BYTES) : BLEN_W'(NARROW);

   // host side handshakes
   assign h_wready = active && (dir_q == DIR_TO_CARD) && !full_q[hptr] && (h_rem != '0);
   assign h_rvalid = active && (dir_q == DIR_FROM_CARD) && full_q[hptr];
   assign host_we  = h_wready && h_wvalid;
   assign host_go  = host_we || (h_rvalid && h_rready);
   assign h_last   = (dir_q == DIR_TO_CARD)
                   ? ((hoff + BLEN_W'(HOST_BYTES) == bufsz) || (h_rem == LEN_W'(HOST_BYTES)))
                   : (hoff + BLEN_W'(HOST_BYTES) == blen[hptr]);
   assign host_addr = hoff[OFF_W-1:0];

   // card side handshakes
   assign c_tx_valid = active && (dir_q == DIR_TO_CARD) && full_q[cptr];
   assign c_rx_ready = active && (dir_q == DIR_FROM_CARD) && !full_q[cptr] && (c_rem != '0);
   assign card_we    = c_rx_ready && c_rx_valid;
   assign card_go    = card_we || (c_tx_valid && c_tx_ready);
   assign rx_chunk   = (c_rem < LEN_W'(bufsz)) ? BLEN_W'(c_rem) : bufsz;
   assign card_bytes = (dir_q == DIR_FROM_CARD) ? rx_chunk : blen[cptr];
   assign card_units = wide_q ? {2'b00, card_bytes, 1'b0} : {card_bytes, 3'b000};
   assign c_last     = (UNIT_W'(cunit) + UNIT_W'(1)) == card_units;
   assign card_addr  = cunit[ADDR_W-1:0];

   assign xfer_done = (full_q == 2'b00) && !host_go && !card_go &&
                      ((dir_q == DIR_FROM_CARD) ? (c_rem == '0) : (h_rem == '0));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         dir_q  <= DIR_TO_CARD;
         wide_q <= 1'b0;
         h_rem  <= '0;
         c_rem  <= '0;
         full_q <= 2'b00;
         hptr   <= 1'b0;
         cptr   <= 1'b0;
         hoff   <= '0;
         cunit  <= '0;
         for (int i = 0; i < 2; i++) blen[i] <= '0;
      end else if (abort) begin
         active <= 1'b0;
         h_rem  <= '0;
         c_rem  <= '0;
         full_q <= 2'b00;
         hptr   <= 1'b0;
         cptr   <= 1'b0;
         hoff   <= '0;
         cunit  <= '0;
      end else if (!active) begin
         if (start) begin
            active <= 1'b1;
            dir_q  <= rx_i ? DIR_FROM_CARD : DIR_TO_CARD;
            wide_q <= wide_i;
            h_rem  <= len_i;
            c_rem  <= len_i;
            hptr   <= 1'b0;
            cptr   <= 1'b0;
            hoff   <= '0;
            cunit  <= '0;
         end
      end else begin
         if (host_go) begin
            if (dir_q == DIR_TO_CARD) h_rem <= h_rem - LEN_W'(HOST_BYTES);
            if (h_last) begin
               hoff         <= '0;
               hptr         <= ~hptr;
               full_q[hptr] <= (dir_q == DIR_TO_CARD);
               if (dir_q == DIR_TO_CARD) blen[hptr] <= hoff + BLEN_W'(HOST_BYTES);
            end else begin
               hoff <= hoff + BLEN_W'(HOST_BYTES);
            end
         end
         if (card_go) begin
            if (c_last) begin
               cunit        <= '0;
               cptr         <= ~cptr;
               full_q[cptr] <= (dir_q == DIR_FROM_CARD);
               if (dir_q == DIR_FROM_CARD) begin
                  blen[cptr] <= rx_chunk;
                  c_rem      <= c_rem - LEN_W'(rx_chunk);
               end
            end else begin
               cunit <= cunit + CU_W'(1);
            end
         end
         if (xfer_done) active <= 1'b0;
      end
   end

   // status flags, one slice per buffer
   for (genvar i = 0; i < 2; i++) begin : g_flag
      logic busy;
      assign busy = active &&
                    (((dir_q == DIR_TO_CARD) && (hptr == 1'(i)) && (hoff != '0)) ||
                     ((dir_q == DIR_FROM_CARD) && (cptr == 1'(i)) && (cunit != '0)));
      assign buf_full[i]  = full_q[i];
      assign buf_empty[i] = !full_q[i] && !busy;
   end

   assign wr_rdy   = h_wready;
   assign rd_rdy   = h_rvalid;
   assign dma_req  = wr_rdy || rd_rdy;
   assign clk_stop = active && (dir_q == DIR_FROM_CARD) && (full_q == 2'b11);

   // R4: transmission starts only from a completed buffer
   a_r4_tx_whole_buffer: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(c_tx_valid) |-> ((blen[cptr] == bufsz) || (h_rem == '0)));
   // R5: read-ready implies a full buffer exists
   a_r5_rd_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
      rd_rdy |-> (buf_full != 2'b00));
   // R6: no card data accepted during a clock stop
   a_r6_stop_blocks_rx: assert property (@(posedge clk) disable iff (!rst_n)
      clk_stop |-> !c_rx_ready);
   // R7: stop released only with a buffer free
   a_r7_release_frees: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_stop) |-> (buf_empty != 2'b00));
   // R10: abort empties both buffers and clears the request
   a_r10_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> ((buf_empty == 2'b11) && !dma_req && !clk_stop));
   // R11: captured mode stays fixed during a transfer
   a_r11_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
      (active && $past(active)) |-> ($stable(wide_q) && $stable(dir_q)));
endmodule

// File: rtl/sd_pingpong_store.sv
module sd_pingpong_store
   import sd_pingpong_pkg::*;
#(
   parameter int BUF_BYTES  = 64,
   parameter int HOST_BYTES = 4,
   localparam int CONT_BITS = BUF_BYTES * 8 / SD_LINES,
   localparam int ADDR_W    = $clog2(CONT_BITS),
   localparam int OFF_W     = $clog2(BUF_BYTES)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wide,
   input  logic                    host_we,
   input  logic                    host_buf,
   input  logic [OFF_W-1:0]        host_off,
   input  logic [HOST_BYTES*8-1:0] host_wdata,
   output logic [HOST_BYTES*8-1:0] host_rdata,
   input  logic                    card_we,
   input  logic                    card_buf,
   input  logic [ADDR_W-1:0]       card_addr,
   input  sd_unit_t                card_wunit,
   output sd_unit_t                card_runit
);
   // one container per data line, per buffer
   logic [CONT_BITS-1:0] cont [2][SD_LINES];

   always_ff @(posedge clk) begin
      if (host_we) begin
         for (int k = 0; k < HOST_BYTES; k++) begin
            if (wide) begin
               for (int j = 0; j < SD_LINES; j++) begin
                  cont[host_buf][j][ADDR_W'(2 * (int'(host_off) + k))]     <= host_wdata[8*k + 4 + j];
                  cont[host_buf][j][ADDR_W'(2 * (int'(host_off) + k) + 1)] <= host_wdata[8*k + j];
               end
            end else begin
               for (int j = 0; j < 8; j++)
                  cont[host_buf][0][ADDR_W'(8 * (int'(host_off) + k) + 7 - j)] <= host_wdata[8*k + j];
            end
         end
      end
      if (card_we) begin
         if (wide) begin
            for (int j = 0; j < SD_LINES; j++) cont[card_buf][j][card_addr] <= card_wunit[j];
         end else begin
            cont[card_buf][0][card_addr] <= card_wunit[0];
         end
      end
   end

   always_comb begin
      host_rdata = '0;
      for (int k = 0; k < HOST_BYTES; k++) begin
         if (wide) begin
            for (int j = 0; j < SD_LINES; j++) begin
               host_rdata[8*k + 4 + j] = cont[host_buf][j][ADDR_W'(2 * (int'(host_off) + k))];
               host_rdata[8*k + j]     = cont[host_buf][j][ADDR_W'(2 * (int'(host_off) + k) + 1)];
            end
         end else begin
            for (int j = 0; j < 8; j++)
               host_rdata[8*k + j] = cont[host_buf][0][ADDR_W'(8 * (int'(host_off) + k) + 7 - j)];
         end
      end
   end

   for (genvar l = 0; l < SD_LINES; l++) begin : g_lane
      if (l == 0) begin : g_base
         assign card_runit[l] = cont[card_buf][0][card_addr];
      end else begin : g_upper
         assign card_runit[l] = wide ? cont[card_buf][l][card_addr] : 1'b0;
      end
   end

   // R8: host and card never touch the same buffer in one cycle
   a_r8_disjoint_buffers: assert property (@(posedge clk) disable iff (!rst_n)
      (host_we && card_we) |-> (host_buf != card_buf));
endmodule

// File: rtl/sd_pingpong_buf.sv
module sd_pingpong_buf
   import sd_pingpong_pkg::*;
#(
   parameter int BUF_BYTES = 64,
   parameter int HOST_W    = 32,
   parameter int LEN_W     = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer_start,
   input  logic              xfer_abort,
   input  logic              xfer_rx,
   input  logic              bus_wide,
   input  logic [LEN_W-1:0]  xfer_bytes,
   input  logic [HOST_W-1:0] host_wdata,
   input  logic              host_wvalid,
   output logic              host_wready,
   output logic [HOST_W-1:0] host_rdata,
   output logic              host_rvalid,
   input  logic              host_rready,
   output logic [3:0]        card_tx_data,
   output logic              card_tx_valid,
   input  logic              card_tx_ready,
   input  logic [3:0]        card_rx_data,
   input  logic              card_rx_valid,
   output logic              card_rx_ready,
   output logic              dma_req,
   output logic              wr_rdy,
   output logic              rd_rdy,
   output logic [1:0]        buf_full,
   output logic [1:0]        buf_empty,
   output logic              clk_stop_req
);
   localparam int HOST_BYTES = HOST_W / 8;
   localparam int OFF_W      = $clog2(BUF_BYTES);
   localparam int ADDR_W     = $clog2(BUF_BYTES * 8 / SD_LINES);

   if (HOST_W % 8 != 0) begin : g_chk_host
      $error("HOST_W must be whole bytes");
   end
   if ((BUF_BYTES & (BUF_BYTES - 1)) != 0 || BUF_BYTES % (SD_LINES * HOST_BYTES) != 0) begin : g_chk_buf
      $error("BUF_BYTES must be a power of two and a multiple of the lines times the host bytes");
   end
   if (LEN_W < $clog2(BUF_BYTES + 1)) begin : g_chk_len
      $error("LEN_W too narrow for one buffer");
   end

   logic              wide_q, hptr, cptr, host_we, card_we;
   logic [OFF_W-1:0]  host_addr;
   logic [ADDR_W-1:0] card_addr;
   sd_unit_t          tx_unit;

   sd_pingpong_ctrl #(
      .BUF_BYTES (BUF_BYTES),
      .HOST_BYTES(HOST_BYTES),
      .LEN_W     (LEN_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .abort     (xfer_abort),
      .start     (xfer_start),
      .rx_i      (xfer_rx),
      .wide_i    (bus_wide),
      .len_i     (xfer_bytes),
      .h_wvalid  (host_wvalid),
      .h_wready  (host_wready),
      .h_rvalid  (host_rvalid),
      .h_rready  (host_rready),
      .c_tx_valid(card_tx_valid),
      .c_tx_ready(card_tx_ready),
      .c_rx_valid(card_rx_valid),
      .c_rx_ready(card_rx_ready),
      .wide_q    (wide_q),
      .hptr      (hptr),
      .host_addr (host_addr),
      .host_we   (host_we),
      .cptr      (cptr),
      .card_addr (card_addr),
      .card_we   (card_we),
      .dma_req   (dma_req),
      .wr_rdy    (wr_rdy),
      .rd_rdy    (rd_rdy),
      .buf_full  (buf_full),
      .buf_empty (buf_empty),
      .clk_stop  (clk_stop_req)
   );

   sd_pingpong_store #(
      .BUF_BYTES (BUF_BYTES),
      .HOST_BYTES(HOST_BYTES)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wide      (wide_q),
      .host_we   (host_we),
      .host_buf  (hptr),
      .host_off  (host_addr),
      .host_wdata(host_wdata),
      .host_rdata(host_rdata),
      .card_we   (card_we),
      .card_buf  (cptr),
      .card_addr (card_addr),
      .card_wunit(sd_unit_t'(card_rx_data)),
      .card_runit(tx_unit)
   );

   assign card_tx_data = tx_unit;
endmodule

// File: tb/sd_pingpong_buf_bench.sv
module sd_pingpong_buf_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xfer_start = 1'b0, xfer_abort = 1'b0, xfer_rx = 1'b0, bus_wide = 1'b0;
   logic [15:0] xfer_bytes = '0;
   logic [31:0] host_wdata = '0;
   logic        host_wvalid = 1'b0, host_rready = 1'b0;
   logic        card_tx_ready = 1'b0, card_rx_valid = 1'b0;
   logic [3:0]  card_rx_data = '0;
   logic [31:0] host_rdata;
   logic        host_wready, host_rvalid, card_tx_valid, card_rx_ready;
   logic [3:0]  card_tx_data;
   logic        dma_req, wr_rdy, rd_rdy, clk_stop_req;
   logic [1:0]  buf_full, buf_empty;

   sd_pingpong_buf u_sd_pingpong_buf (.*);

   always #10 clk = ~clk;

   int     n_chk = 0, n_bad = 0, cyc = 0, host_acc = 0;
   logic [7:0] src [256];

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog (all requirements) actual=%0d expected=0", cyc);
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   function automatic logic [31:0] word_at(input int i);
      return {src[i+3], src[i+2], src[i+1], src[i]};
   endfunction

   // expected line unit u of the byte stream (R2)
   function automatic logic [3:0] unit_at(input int u, input bit wide);
      logic [7:0] b;
      if (wide) begin
         b = src[u/2];
         return (u % 2 == 0) ? b[7:4] : b[3:0];
      end
      b = src[u/8];
      return {3'b000, b[7 - (u % 8)]};
   endfunction

   task automatic refill();
      for (int i = 0; i < 256; i++) src[i] = 8'($urandom);
   endtask

   task automatic start_xfer(input bit rx, input bit wide, input int len);
      @(negedge clk);
      xfer_rx = rx; bus_wide = wide; xfer_bytes = 16'(len); xfer_start = 1'b1;
      @(negedge clk);
      xfer_start = 1'b0;
   endtask

   task automatic idle_check(input string tag);
      repeat (4) @(negedge clk);
      chk(buf_empty == 2'b11, {tag, " R12 empty after end"}, buf_empty, 3);
      chk(!dma_req, {tag, " R12 dma idle after end"}, dma_req, 0);
   endtask

   task automatic run_stream(input bit rx, input bit wide, input int len, input int pct, input bit scramble);
      int errs = 0;
      bit first_tx = 1'b1;
      int bsz = wide ? 64 : 16;
      int total = wide ? len * 2 : len * 8;
      refill();
      host_acc = 0;
      start_xfer(rx, wide, len);
      if (!rx) chk(host_wready && wr_rdy && dma_req, "R3 write ready with dma at start", {host_wready, wr_rdy, dma_req}, 7);
      if (scramble) begin
         bus_wide = ~wide; xfer_rx = ~rx; xfer_bytes = 16'd12;   // R11
      end
      fork
         begin : host_side
            int idx = 0;
            while (idx < len) begin
               @(negedge clk);
               if (!rx) begin
                  host_wvalid = (($urandom % 100) < pct);
                  host_wdata  = word_at(idx);
                  if (host_wvalid && host_wready) begin idx += 4; host_acc = idx; end
               end else begin
                  host_rready = (($urandom % 100) < pct);
                  if (host_rvalid && host_rready) begin
                     if (host_rdata !== word_at(idx)) begin
                        if (errs == 0) $display("FAIL R3 read word %0d actual=%h expected=%h", idx, host_rdata, word_at(idx));
                        errs++;
                     end
                     idx += 4;
                  end
               end
            end
            @(negedge clk);
            host_wvalid = 1'b0; host_rready = 1'b0;
         end
         begin : card_side
            int u = 0;
            while (u < total) begin
               @(negedge clk);
               if (!rx) begin
                  card_tx_ready = (($urandom % 100) < pct);
                  if (card_tx_valid && first_tx) begin
                     first_tx = 1'b0;
                     chk(host_acc >= ((len < bsz) ? len : bsz), "R4 tx only after buffer complete", host_acc, bsz);
                  end
                  if (card_tx_valid && card_tx_ready) begin
                     if (card_tx_data !== unit_at(u, wide)) begin
                        if (errs == 0) $display("FAIL R2 tx unit %0d actual=%h expected=%h", u, card_tx_data, unit_at(u, wide));
                        errs++;
                     end
                     u++;
                  end
               end else begin
                  card_rx_valid = (($urandom % 100) < pct);
                  card_rx_data  = wide ? unit_at(u, 1'b1) : {3'($urandom), unit_at(u, 1'b0)[0]};
                  if (card_rx_valid && card_rx_ready) u++;
               end
            end
            @(negedge clk);
            card_tx_ready = 1'b0; card_rx_valid = 1'b0;
         end
      join
      chk(errs == 0, $sformatf("R2 R6 stream data rx=%0d wide=%0d len=%0d", rx, wide, len), errs, 0);
      idle_check("stream");
   endtask

   // push n accepted card units starting at unit base
   task automatic push_units(input int base, input int n, input bit wide);
      int u = 0;
      while (u < n) begin
         @(negedge clk);
         card_rx_valid = 1'b1;
         card_rx_data  = unit_at(base + u, wide);
         if (card_rx_ready) u++;
      end
      @(negedge clk);
      card_rx_valid = 1'b0;
   endtask

   task automatic pull_words(input int base, input int n, input string tag);
      int idx = 0, errs = 0;
      while (idx < n) begin
         @(negedge clk);
         host_rready = 1'b1;
         if (host_rvalid) begin
            if (host_rdata !== word_at(base + idx)) errs++;
            idx += 4;
         end
      end
      @(negedge clk);
      host_rready = 1'b0;
      chk(errs == 0, tag, errs, 0);
   endtask

   initial begin
      void'($urandom(32'h5eed_0042));
      repeat (5) @(negedge clk);
      chk(buf_empty == 2'b11 && buf_full == 2'b00, "R1 reset flags", {buf_full, buf_empty}, 3);
      chk(!dma_req && !wr_rdy && !rd_rdy && !clk_stop_req, "R1 reset requests", {dma_req, wr_rdy, rd_rdy, clk_stop_req}, 0);
      chk(!host_wready && !host_rvalid && !card_tx_valid && !card_rx_ready, "R1 reset handshakes", 1, 0);
      rst_n = 1'b1;

      run_stream(1'b0, 1'b1, 200, 75, 1'b0);  // write, 4-bit, partial last buffer (R9)
      run_stream(1'b0, 1'b0, 36, 60, 1'b0);   // write, 1-bit
      run_stream(1'b1, 1'b1, 200, 70, 1'b0);  // read, 4-bit
      run_stream(1'b1, 1'b0, 36, 80, 1'b0);   // read, 1-bit with noisy upper lines
      run_stream(1'b0, 1'b1, 100, 100, 1'b1); // R11 inputs flipped mid-transfer
      run_stream(1'b1, 1'b0, 48, 50, 1'b1);   // R11 read side

      // directed: host stalls, card fills both buffers
      refill();
      start_xfer(1'b1, 1'b1, 192);
      push_units(0, 128, 1'b1);
      chk(buf_full == 2'b01, "R8 X fills first", buf_full, 1);
      chk(rd_rdy && dma_req && host_rvalid, "R5 read ready with dma", {rd_rdy, dma_req, host_rvalid}, 7);
      chk(!clk_stop_req, "R7 no stop with one free", clk_stop_req, 0);
      push_units(128, 128, 1'b1);
      chk(buf_full == 2'b11, "R8 Y fills second", buf_full, 3);
      chk(clk_stop_req, "R7 stop when both full", clk_stop_req, 1);
      chk(!card_rx_ready, "R6 no rx ready when both full", card_rx_ready, 0);
      repeat (6) begin
         @(negedge clk);
         card_rx_valid = 1'b1; card_rx_data = 4'($urandom);
      end
      @(negedge clk);
      card_rx_valid = 1'b0;
      chk(buf_full == 2'b11 && clk_stop_req, "R7 stop held while host idle", buf_full, 3);
      pull_words(0, 64, "R6 data offered during stop ignored (X intact)");
      chk(!clk_stop_req, "R7 stop released after drain", clk_stop_req, 0);
      chk(buf_full == 2'b10, "R8 X freed after all bytes fetched", buf_full, 2);
      chk(card_rx_ready, "R6 rx ready again", card_rx_ready, 1);
      @(negedge clk);
      xfer_abort = 1'b1;
      @(negedge clk);
      xfer_abort = 1'b0;
      chk(buf_empty == 2'b11 && buf_full == 2'b00, "R10 abort empties", {buf_full, buf_empty}, 3);
      chk(!dma_req && !clk_stop_req, "R10 abort drops requests", {dma_req, clk_stop_req}, 0);

      // after abort the next transfer starts in X
      refill();
      start_xfer(1'b1, 1'b1, 64);
      push_units(0, 128, 1'b1);
      chk(buf_full == 2'b01, "R10 restart uses X", buf_full, 1);
      pull_words(0, 64, "R5 read data after restart");
      idle_check("restart");

      // short block: full only after its final nibble
      refill();
      start_xfer(1'b1, 1'b1, 8);
      push_units(0, 15, 1'b1);
      chk(buf_full == 2'b00 && !rd_rdy, "R9 short block not full early", buf_full, 0);
      push_units(15, 1, 1'b1);
      chk(buf_full == 2'b01 && rd_rdy, "R9 short block full at end", buf_full, 1);
      pull_words(0, 8, "R9 short block data");
      idle_check("short");

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule